// File: doc/BRIEF.md
# Serial SAR converter interface emulator

This block models the digital side of a two-channel, 12-bit successive-approximation converter, seen from the serial bus as a slave device. The analog inputs are replaced by two parallel sample ports. A bus master lowers the active-low select line to start a cycle. While the line is high the part is shut down and its data pin is released. At the moment of selection, the serial clock level decides where the conversion clock comes from. A low level gives external mode, where the serial clock itself paces the conversion. A high level gives internal mode, where an on-chip oscillator runs the conversion. That oscillator is derived here from the system clock by a divider. Each select cycle takes the next channel in strict alternation. The result leaves as a 16-bit frame, most significant bit first, and each bit changes after a serial clock falling edge.

In external mode the second falling edge takes the sample. In internal mode the first falling edge takes the sample and starts the oscillator. The data pin then stays low while the conversion runs and goes high once it is done, which serves as the end-of-conversion flag. A parameter turns the block into a single-pair pseudo-differential variant. That variant always converts port 0 and always reports channel ID 0. All pins are sampled on the system clock, so the serial clock must be much slower than it.

Top module: `sadc_serial_if`

## Requirements
- R1: The sclk level seen in the system-clock cycle where cs_n is first seen low fixes the mode for the whole cycle: low selects external mode, in which the first sclk falling edge already drives dout to 1, and high selects internal mode, in which dout stays 0 after that edge.
- R2: While selected and before the first sclk falling edge, dout is 0. After falling edge k (k = 1..16) dout carries frame bit k. Bits 1 to 3 are 1, bit 4 is the channel ID, and bits 5 to 16 are the 12 data bits, MSB first. In external mode bit 1 is a plain 1.
- R3: The data word is copied from the selected channel's port at the sampling edge, which is falling edge 2 in external mode and falling edge 1 in internal mode. Port changes after that edge do not alter the frame.
- R4: In internal mode, falling edge 1 starts a conversion lasting CONV_CYCLES × OSC_DIV system clocks. During it dout is 0. When it ends, dout goes to 1 (the end-of-conversion flag, frame bit 1) and stays there until falling edge 2.
- R5: sclk falling edges that arrive while an internal conversion runs are ignored and do not advance the frame.
- R6: The first select cycle after reset uses channel 0, and every later cs_n falling edge switches channel. A select that is dropped without a conversion still consumes a channel, so two selects between conversions repeat a channel. The channel ID bit is 0 for channel 0 and 1 for channel 1.
- R7: After falling edge 16, further falling edges while cs_n stays low leave dout at 0.
- R8: Within two system clocks of cs_n going high, dout_oe is 0 and dout is 0. After reset dout_oe is 0. dout_oe is 1 within two system clocks of a cs_n falling edge.
- R9: Raising cs_n during an internal conversion aborts it. No end-of-conversion flag appears, the pins stay released, and the next select starts a fresh frame on the next channel in turn.
- R10: With PSEUDO_DIFF set, every frame carries port 0 data and channel ID 0, whatever the select count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; also the source of the internal oscillator |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low select; high means shutdown |
| sclk | input | 1 | Serial clock from the bus master |
| ch0_data | input | DATA_W | Sample value standing in for analog channel 0 |
| ch1_data | input | DATA_W | Sample value standing in for analog channel 1 |
| dout | output | 1 | Serial data, forced 0 while released |
| dout_oe | output | 1 | Drive enable for dout; 0 means high impedance |

## Verification
The bench clocks an extra sclk pulse into the middle of an internal conversion. A design that counted that pulse would shift the whole frame by one bit and show the channel ID where a leading one belongs. It changes the sample ports right after the sampling edge, which exposes a design that reads the ports live rather than latching them. It aborts a conversion and then issues a dummy select. A design that did not advance the channel on every select, or that kept a stale end-of-conversion state, would then report the wrong channel ID or a raised flag. A second instance in the pseudo-differential variant runs the same stimulus, so a stray port 1 value or a channel ID of 1 from that variant would show up.

// File: rtl/sadc_pkg.sv
package sadc_pkg;

  // number of frame bits ahead of the data word: three ones and the channel ID
  localparam int unsigned HDR_W = 4;

  typedef enum logic [1:0] {
    ST_OFF  = 2'd0,
    ST_ACT  = 2'd1,
    ST_CONV = 2'd2
  } sadc_state_e;

  typedef enum logic {
    CLK_EXT = 1'b0,
    CLK_INT = 1'b1
  } sadc_clk_e;

endpackage

// File: rtl/sadc_edge.sv
module sadc_edge #(
  parameter int unsigned W       = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] sig_i,
  output logic [W-1:0] fall_o
);

  logic [W-1:0] sig_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sig_q <= RST_VAL;
    else        sig_q <= sig_i;
  end

  // a high-to-low change seen between the previous and the current cycle
  assign fall_o = sig_q & ~sig_i;

endmodule

// File: rtl/sadc_osc.sv
module sadc_osc #(
  parameter int unsigned OSC_DIV     = 4,
  parameter int unsigned CONV_CYCLES = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic abort_i,
  output logic busy_o,
  output logic done_o
);

  localparam int unsigned DIV_W = (OSC_DIV > 2) ? $clog2(OSC_DIV) : 1;
  localparam int unsigned CYC_W = $clog2(CONV_CYCLES + 1);

  logic [DIV_W-1:0] div_q;
  logic [CYC_W-1:0] cyc_q;
  logic             tick;

  // one oscillator period every OSC_DIV system clocks
  assign tick = busy_o && (div_q == DIV_W'(OSC_DIV - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_o <= 1'b0;
      done_o <= 1'b0;
      div_q  <= '0;
      cyc_q  <= '0;
    end else begin
      done_o <= 1'b0;
      if (abort_i) begin
        busy_o <= 1'b0;
        div_q  <= '0;
        cyc_q  <= '0;
      end else if (start_i && !busy_o) begin
        busy_o <= 1'b1;
        div_q  <= '0;
        cyc_q  <= '0;
      end else if (busy_o) begin
        if (tick) begin
          div_q <= '0;
          if (cyc_q == CYC_W'(CONV_CYCLES - 1)) begin
            busy_o <= 1'b0;
            done_o <= 1'b1;
            cyc_q  <= '0;
          end else begin
            cyc_q <= cyc_q + CYC_W'(1);
          end
        end else begin
          div_q <= div_q + DIV_W'(1);
        end
      end
    end
  end

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R4

  AST_OSC_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o && !abort_i) |=> (busy_o && !done_o)); // R4

  AST_ABORT_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    abort_i |=> (!busy_o && !done_o)); // R9

endmodule

// File: rtl/sadc_frame_bit.sv
module sadc_frame_bit
  import sadc_pkg::*;
#(
  parameter int unsigned DATA_W = 12,
  parameter int unsigned POS_W  = 5
) (
  input  logic [POS_W-1:0]  pos_i,
  input  sadc_clk_e         mode_i,
  input  logic              eoc_i,
  input  logic              chid_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              bit_o
);

  localparam int unsigned FRAME_W = HDR_W + DATA_W;
  localparam int unsigned IDX_W   = (DATA_W > 2) ? $clog2(DATA_W) : 1;

  logic [POS_W-1:0] rev;
  logic [IDX_W-1:0] idx;

  // data bit position: MSB right after the header, LSB at the last frame bit
  assign rev = POS_W'(FRAME_W) - pos_i;
  assign idx = rev[IDX_W-1:0];

  always_comb begin
    if (pos_i == '0)
      bit_o = 1'b0;
    else if (pos_i == POS_W'(1))
      bit_o = (mode_i == CLK_EXT) ? 1'b1 : eoc_i;
    else if (pos_i < POS_W'(HDR_W))
      bit_o = 1'b1;
    else if (pos_i == POS_W'(HDR_W))
      bit_o = chid_i;
    else if (pos_i <= POS_W'(FRAME_W))
      bit_o = data_i[idx];
    else
      bit_o = 1'b0;
  end

endmodule

// File: rtl/sadc_serial_if.sv
module sadc_serial_if
  import sadc_pkg::*;
#(
  parameter int unsigned DATA_W      = 12,
  parameter int unsigned OSC_DIV     = 4,
  parameter int unsigned CONV_CYCLES = 12,
  parameter bit          PSEUDO_DIFF = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sclk,
  input  logic [DATA_W-1:0] ch0_data,
  input  logic [DATA_W-1:0] ch1_data,
  output logic              dout,
  output logic              dout_oe
);

  localparam int unsigned FRAME_W = HDR_W + DATA_W;
  localparam int unsigned POS_W   = $clog2(FRAME_W + 2);
  localparam logic [POS_W-1:0] P_MAX        = POS_W'(FRAME_W + 1);
  localparam logic [POS_W-1:0] P_EXT_SAMPLE = POS_W'(2);
  localparam logic [POS_W-1:0] P_FRAME_END  = POS_W'(FRAME_W);

  sadc_state_e       state_q;
  sadc_clk_e         mode_q;
  logic [POS_W-1:0]  pos_q;
  logic              eoc_q;
  logic [DATA_W-1:0] sample_q;
  logic              cur_ch;
  logic [DATA_W-1:0] pick;
  logic [1:0]        fall_vec;
  logic              cs_fall;
  logic              sclk_fall;
  logic              bump;
  logic              latch;
  logic              conv_go;
  logic              osc_busy;
  logic              osc_done;
  logic              frame_bit;

  // bit 1 watches the select line, bit 0 the serial clock
  sadc_edge #(.W(2), .RST_VAL(2'b10)) u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .sig_i  ({cs_n, sclk}),
    .fall_o (fall_vec)
  );

  assign cs_fall   = fall_vec[1];
  assign sclk_fall = fall_vec[0];

  // channel pointer: alternating pair or fixed single pair
  generate
    if (PSEUDO_DIFF) begin : g_pair
      assign cur_ch = 1'b0;
    end else begin : g_dual
      logic nxt_ch;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          nxt_ch <= 1'b0;
          cur_ch <= 1'b1;
        end else if (cs_fall) begin
          cur_ch <= nxt_ch;
          nxt_ch <= ~nxt_ch;
        end
      end

      AST_CH_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
        cs_fall |=> (cur_ch != $past(cur_ch))); // R6
    end
  endgenerate

  assign pick = cur_ch ? ch1_data : ch0_data;

  // a counted serial clock falling edge within the frame
  assign bump    = (state_q == ST_ACT) && sclk_fall && !cs_n && (pos_q != P_MAX);
  assign latch   = bump && (((mode_q == CLK_EXT) && (pos_q == P_EXT_SAMPLE - POS_W'(1))) ||
                            ((mode_q == CLK_INT) && (pos_q == '0)));
  assign conv_go = bump && (mode_q == CLK_INT) && (pos_q == '0) && !osc_busy;

  sadc_osc #(.OSC_DIV(OSC_DIV), .CONV_CYCLES(CONV_CYCLES)) u_osc (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (conv_go),
    .abort_i (cs_n),
    .busy_o  (osc_busy),
    .done_o  (osc_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_OFF;
      mode_q   <= CLK_EXT;
      pos_q    <= '0;
      eoc_q    <= 1'b0;
      sample_q <= '0;
    end else if (cs_n) begin
      state_q <= ST_OFF;
      eoc_q   <= 1'b0;
    end else if (cs_fall) begin
      state_q <= ST_ACT;
      mode_q  <= sclk ? CLK_INT : CLK_EXT;
      pos_q   <= '0;
      eoc_q   <= 1'b0;
    end else begin
      unique case (state_q)
        ST_ACT: begin
          if (bump)    pos_q    <= pos_q + POS_W'(1);
          if (latch)   sample_q <= pick;
          if (conv_go) state_q  <= ST_CONV;
        end
        ST_CONV: begin
          if (osc_done) begin
            eoc_q   <= 1'b1;
            state_q <= ST_ACT;
          end
        end
        default: state_q <= ST_OFF;
      endcase
    end
  end

  sadc_frame_bit #(.DATA_W(DATA_W), .POS_W(POS_W)) u_bit (
    .pos_i  (pos_q),
    .mode_i (mode_q),
    .eoc_i  (eoc_q),
    .chid_i (cur_ch),
    .data_i (sample_q),
    .bit_o  (frame_bit)
  );

  assign dout_oe = (state_q != ST_OFF);
  assign dout    = dout_oe & frame_bit;

  AST_HIZ_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n && $past(cs_n)) |-> !dout_oe); // R8

  AST_CONV_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_CONV) |=> $stable(pos_q)); // R5

  AST_TRAIL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (dout_oe && (pos_q > P_FRAME_END)) |-> !dout); // R7

  AST_LEAD_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    (dout_oe && (pos_q >= POS_W'(2)) && (pos_q < POS_W'(HDR_W))) |-> dout); // R2

  AST_SAMPLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q != ST_OFF) && !cs_fall && (pos_q > P_EXT_SAMPLE)) |=> $stable(sample_q)); // R3

  AST_EOC_INT_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    eoc_q |-> (mode_q == CLK_INT)); // R4

endmodule

// File: tb/sadc_serial_if_tb.sv
module sadc_serial_if_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_n = 1'b1;
  logic        sclk = 1'b0;
  logic [11:0] ch0_s = 12'hA5C;
  logic [11:0] ch1_s = 12'h3E1;
  logic        dout, dout_oe, dout_pd, dout_oe_pd;

  int n_chk = 0;
  int n_bad = 0;

  typedef struct {
    logic  em;
    logic  ep;
    string req;
  } item_t;

  item_t q[$];
  logic  obs_m, obs_p;
  event  obs_ev;

  always #10 clk = ~clk;

  sadc_serial_if u_dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk),
    .ch0_data(ch0_s), .ch1_data(ch1_s), .dout(dout), .dout_oe(dout_oe)
  );

  sadc_serial_if #(.PSEUDO_DIFF(1'b1)) u_dut_pd (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk),
    .ch0_data(ch0_s), .ch1_data(ch1_s), .dout(dout_pd), .dout_oe(dout_oe_pd)
  );

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  task automatic chk(input logic act, input logic exp, input string req);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%b expected=%b", req, act, exp);
    end
  endtask

  // monitor: pops expected bits and compares them with what was observed
  initial begin
    forever begin
      item_t it;
      @(obs_ev);
      if (q.size() == 0) begin
        n_chk++;
        n_bad++;
        $display("FAIL scoreboard: actual=observation expected=queued item");
      end else begin
        it = q.pop_front();
        chk(obs_m, it.em, it.req);
        chk(obs_p, it.ep, "R10");
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    summary();
  end

  task automatic push(input logic em, input logic ep, input string req);
    item_t it;
    it.em = em;
    it.ep = ep;
    it.req = req;
    q.push_back(it);
  endtask

  task automatic observe();
    obs_m = dout;
    obs_p = dout_pd;
    ->obs_ev;
    @(negedge clk);
  endtask

  task automatic clk_bit();
    if (sclk == 1'b0) begin
      sclk = 1'b1;
      repeat (6) @(negedge clk);
    end
    sclk = 1'b0;
    repeat (6) @(negedge clk);
    observe();
    sclk = 1'b1;
    repeat (5) @(negedge clk);
  endtask

  task automatic sel(input logic imode);
    sclk = imode;
    repeat (3) @(negedge clk);
    cs_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(dout_oe, 1'b1, "R8");
  endtask

  task automatic desel();
    cs_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(dout_oe, 1'b0, "R8");
    chk(dout, 1'b0, "R8");
    chk(dout_oe_pd, 1'b0, "R8");
  endtask

  function automatic logic fbit(input int k, input logic chid, input logic [11:0] d);
    if (k <= 3) return 1'b1;
    if (k == 4) return chid;
    if (k <= 16) return d[16-k];
    return 1'b0;
  endfunction

  task automatic run_frame(input logic imode, input logic chid,
                           input logic [11:0] dm, input logic [11:0] dp,
                           input int chg_at, input logic [11:0] n0,
                           input logic [11:0] n1, input int trail);
    string r;
    sel(imode);
    push(1'b0, 1'b0, "R2");
    observe();
    for (int k = 1; k <= 16; k++) begin
      if (imode && k == 1) begin
        push(1'b0, 1'b0, "R1");
        clk_bit();
        // stray pulse while converting: must not be counted
        sclk = 1'b0;
        repeat (4) @(negedge clk);
        sclk = 1'b1;
        repeat (4) @(negedge clk);
        repeat (60) @(negedge clk);
        push(1'b1, 1'b1, "R4");
        observe();
      end else begin
        if (k == 1)            r = "R1";
        else if (k == 4)       r = "R6";
        else if (chg_at > 0)   r = "R3";
        else if (imode)        r = "R5";
        else                   r = "R2";
        push(fbit(k, chid, dm), fbit(k, 1'b0, dp), r);
        clk_bit();
      end
      if (k == chg_at) begin
        ch0_s = n0;
        ch1_s = n1;
      end
    end
    for (int t = 0; t < trail; t++) begin
      push(1'b0, 1'b0, "R7");
      clk_bit();
    end
    desel();
  endtask

  initial begin
    repeat (5) @(negedge clk);
    chk(dout_oe, 1'b0, "R8");
    chk(dout, 1'b0, "R8");
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(dout_oe, 1'b0, "R8");

    // first select after reset: channel 0, external mode, trailing zeros
    run_frame(1'b0, 1'b0, 12'hA5C, 12'hA5C, 0, 12'h000, 12'h000, 3);
    // channel 1; port 1 changes right after the sampling edge
    run_frame(1'b0, 1'b1, 12'h3E1, 12'hA5C, 2, 12'hA5C, 12'h0F0, 0);
    // internal mode on channel 0; port 0 changes after the sampling edge
    run_frame(1'b1, 1'b0, 12'hA5C, 12'hA5C, 1, 12'hFFF, 12'h0F0, 1);

    // abort an internal conversion on channel 1
    sel(1'b1);
    push(1'b0, 1'b0, "R9");
    clk_bit();
    cs_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(dout_oe, 1'b0, "R9");
    chk(dout_oe_pd, 1'b0, "R9");
    repeat (60) @(negedge clk);
    chk(dout_oe, 1'b0, "R9");
    chk(dout, 1'b0, "R9");

    // fresh frame after the abort: channel 0 again
    run_frame(1'b0, 1'b0, 12'hFFF, 12'hFFF, 0, 12'h000, 12'h000, 0);

    // dummy select consumes channel 1, so channel 0 repeats
    ch0_s = 12'h001;
    sclk = 1'b0;
    cs_n = 1'b0;
    repeat (3) @(negedge clk);
    cs_n = 1'b1;
    repeat (3) @(negedge clk);
    run_frame(1'b0, 1'b0, 12'h001, 12'h001, 0, 12'h000, 12'h000, 0);

    // internal mode on channel 1
    run_frame(1'b1, 1'b1, 12'h0F0, 12'h001, 0, 12'h000, 12'h000, 2);

    repeat (4) @(negedge clk);
    if (q.size() != 0) begin
      n_chk++;
      n_bad++;
      $display("FAIL scoreboard: actual=%0d expected=0 items left", q.size());
    end
    summary();
  end

endmodule